// File: doc/BRIEF.md
# Configurable Single-Port Synchronous RAM

This block is a single-port synchronous memory. It has one clock, a port enable, a write strobe, an address, a write word and a read word. Every operation happens at a rising clock edge, and only when the port enable is high. A read places the addressed word on the output after the edge. A write stores the input word, and the output then follows one of three policies chosen at elaboration time.

A synchronous output reset forces the read word to a parameterized constant. It never touches the stored words. An optional output register can be enabled. It adds one cycle of read latency, and the output reset then acts on that final register. The block sits behind any logic that needs a small local store with a known read latency.

Top module: `sp_sync_ram`

## Requirements
- R1: When `ena` is low at a rising edge, nothing is stored and `rdata` keeps its value; this holds with or without the output register.
- R2: With `ena` high and `wr_en` low, `rdata` shows the word at `addr` after that edge (one cycle, no output register), and the stored words are unchanged.
- R3: With `WMODE` = write-first (encoding 0), a write stores `wdata` at `addr`, and the same edge puts `wdata` on the output stage.
- R4: With `WMODE` = read-first (encoding 1), a write puts the word previously held at `addr` on the output stage, and `wdata` is stored.
- R5: With `WMODE` = no-change (encoding 2), a write stores `wdata` and leaves the output stage holding its previous value.
- R6: With `ena` and `out_rst` both high, `rdata` becomes `RST_VAL` (default 16'h0101) after the edge. The stored words are not altered, and a write in the same cycle is still stored.
- R7: With `OUT_REG` = 1, every value reaches `rdata` one cycle later than with `OUT_REG` = 0, provided `ena` is high on both edges.
- R8: With `OUT_REG` = 1, the output register loads only when `ena` is high, and `out_rst` loads `RST_VAL` into that final register.
- R9: Before any edge, `rdata` equals `RST_VAL` and every stored word equals `INIT_WORD` (default zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all actions on the rising edge |
| ena | input | 1 | Port enable; low means the edge is ignored |
| wr_en | input | 1 | Write strobe, qualified by `ena` |
| out_rst | input | 1 | Synchronous output reset, qualified by `ena` |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to store |
| rdata | output | DATA_W | Read word |

## Verification
The output reset and a write can fall in the same cycle. That cycle has two outcomes to judge. The output must take the reset constant in every write mode, and the memory must still take the new word. The bench provokes this directly: it writes with `out_rst` high, then reads the same address back. The random phase also raises `out_rst` on about one cycle in ten, with writes happening freely. Every configuration is compared against a reference array model that applies the write and the output reset independently.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Output policy on a write cycle; the encodings are part of the interface.
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

endpackage

// File: rtl/spr_array.sv
module spr_array #(
  parameter int          ADDR_W    = 5,
  parameter int          DATA_W    = 16,
  parameter logic [DATA_W-1:0] INIT_WORD = '0
) (
  input  logic              clk,
  input  logic              store,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cur_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH] = '{default: INIT_WORD};

  // Contents before this edge's write; feeds the output stage.
  assign cur_word = cells[addr];

  always_ff @(posedge clk) begin
    if (store) cells[addr] <= wdata;
  end
endmodule

// File: rtl/spr_first_stage.sv
module spr_first_stage
  import spr_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter wmode_e      WMODE   = WM_WRITE_FIRST,
  parameter bit          OUT_REG = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              ena,
  input  logic              wr_en,
  input  logic              out_rst,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_word,
  output logic [DATA_W-1:0] stage_q
);
  logic [DATA_W-1:0] q = RST_VAL;
  logic [DATA_W-1:0] wr_next;
  logic              rst_here;

  // Without the extra register the reset lands on this stage.
  assign rst_here = out_rst && !OUT_REG;

  generate
    if (WMODE == WM_WRITE_FIRST) begin : g_wf
      assign wr_next = wdata;
    end else if (WMODE == WM_READ_FIRST) begin : g_rf
      assign wr_next = cur_word;
    end else begin : g_nc
      assign wr_next = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ena) begin
      if (rst_here)   q <= RST_VAL;
      else if (wr_en) q <= wr_next;
      else            q <= cur_word;
    end
  end

  assign stage_q = q;
endmodule

// File: rtl/spr_out_stage.sv
module spr_out_stage #(
  parameter int          DATA_W  = 16,
  parameter bit          OUT_REG = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              ena,
  input  logic              out_rst,
  input  logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] rdata
);
  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] q = RST_VAL;
      always_ff @(posedge clk) begin
        if (ena) q <= out_rst ? RST_VAL : stage_q;
      end
      assign rdata = q;
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, ena, out_rst};
      assign rdata = stage_q;
    end
  endgenerate
endmodule

// File: rtl/sp_sync_ram.sv
module sp_sync_ram
  import spr_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter int          DATA_W    = 16,
  parameter wmode_e      WMODE     = WM_WRITE_FIRST,
  parameter bit          OUT_REG   = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL   = 16'h0101,
  parameter logic [DATA_W-1:0] INIT_WORD = '0
) (
  input  logic              clk,
  input  logic              ena,
  input  logic              wr_en,
  input  logic              out_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic              store;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] stage_q;

  // The output reset never blocks storage.
  assign store = ena && wr_en;

  spr_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_WORD(INIT_WORD)
  ) u_array (
    .clk(clk), .store(store), .addr(addr), .wdata(wdata), .cur_word(cur_word)
  );

  spr_first_stage #(
    .DATA_W(DATA_W), .WMODE(WMODE), .OUT_REG(OUT_REG), .RST_VAL(RST_VAL)
  ) u_first (
    .clk(clk), .ena(ena), .wr_en(wr_en), .out_rst(out_rst),
    .wdata(wdata), .cur_word(cur_word), .stage_q(stage_q)
  );

  spr_out_stage #(
    .DATA_W(DATA_W), .OUT_REG(OUT_REG), .RST_VAL(RST_VAL)
  ) u_out (
    .clk(clk), .ena(ena), .out_rst(out_rst), .stage_q(stage_q), .rdata(rdata)
  );
endmodule

// File: rtl/spr_checker.sv
module spr_checker
  import spr_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter wmode_e      WMODE   = WM_WRITE_FIRST,
  parameter bit          OUT_REG = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input logic              clk,
  input logic              ena,
  input logic              wr_en,
  input logic              out_rst,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!armed)
    !ena |=> $stable(rdata));

  p_reset_value_r6: assert property (@(posedge clk) disable iff (!armed)
    (ena && out_rst) |=> (rdata == RST_VAL));

  generate
    if (!OUT_REG && WMODE == WM_WRITE_FIRST) begin : g_wf
      p_write_thru_r3: assert property (@(posedge clk) disable iff (!armed)
        (ena && wr_en && !out_rst) |=> (rdata == $past(wdata)));
    end
    if (!OUT_REG && WMODE == WM_NO_CHANGE) begin : g_nc
      p_keep_on_write_r5: assert property (@(posedge clk) disable iff (!armed)
        (ena && wr_en && !out_rst) |=> $stable(rdata));
    end
    if (OUT_REG && WMODE == WM_WRITE_FIRST) begin : g_reg
      p_extra_cycle_r7: assert property (@(posedge clk) disable iff (!armed)
        (ena && wr_en) ##1 (ena && !out_rst) |=> (rdata == $past(wdata, 2)));
    end
  endgenerate
endmodule

bind sp_sync_ram spr_checker #(
  .DATA_W(DATA_W), .WMODE(WMODE), .OUT_REG(OUT_REG), .RST_VAL(RST_VAL)
) u_spr_checker (.*);

// File: tb/test_sp_sync_ram.sv
module test_sp_sync_ram;
  import spr_pkg::*;

  localparam int AW   = 5;
  localparam int DW   = 16;
  localparam int NCFG = 6;   // cfg k: write mode k%3, output register when k>=3
  localparam logic [DW-1:0] RSTV  = 16'h0101;
  localparam logic [DW-1:0] INITW = 16'h0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          ena = 1'b0, wr_en = 1'b0, out_rst = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_all [NCFG];

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    sp_sync_ram #(
      .ADDR_W(AW), .DATA_W(DW), .WMODE(wmode_e'(k % 3)),
      .OUT_REG(k >= 3), .RST_VAL(RSTV), .INIT_WORD(INITW)
    ) i_sp_sync_ram (
      .clk(clk), .ena(ena), .wr_en(wr_en), .out_rst(out_rst),
      .addr(addr), .wdata(wdata), .rdata(rd_all[k])
    );
  end

  logic [DW-1:0] m_mem [1 << AW];
  logic [DW-1:0] m_lat [NCFG];
  logic [DW-1:0] m_out [NCFG];
  int n_run = 0, n_fail = 0;

  function automatic logic [DW-1:0] exp_of(int c);
    return (c >= 3) ? m_out[c] : m_lat[c];
  endfunction

  function automatic string tag_of(int c, logic e, logic w, logic s);
    if (c >= 3) return (!e || s) ? "R8" : "R7";
    if (!e) return "R1";
    if (s)  return "R6";
    if (!w) return "R2";
    case (c % 3)
      0: return "R3";
      1: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_cfg(int c, string req);
    n_run++;
    if (rd_all[c] !== exp_of(c)) begin
      n_fail++;
      $display("FAIL %s cfg%0d: actual %h expected %h", req, c, rd_all[c], exp_of(c));
    end
  endtask

  // Called at a falling edge; drives, models, and checks at the next falling edge.
  task automatic step(logic e, logic w, logic s, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] old;
    ena = e; wr_en = w; out_rst = s; addr = a; wdata = d;
    old = m_mem[a];
    for (int c = 0; c < NCFG; c++) begin
      if (e) begin
        if (c >= 3) m_out[c] = s ? RSTV : m_lat[c];
        if (s && c < 3) m_lat[c] = RSTV;
        else if (w) begin
          if (c % 3 == 0)      m_lat[c] = d;
          else if (c % 3 == 1) m_lat[c] = old;
        end else m_lat[c] = old;
      end
    end
    if (e && w) m_mem[a] = d;   // R6: a reset in the same cycle still stores
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCFG; c++) check_cfg(c, tag_of(c, e, w, s));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = INITW;
    for (int c = 0; c < NCFG; c++) begin m_lat[c] = RSTV; m_out[c] = RSTV; end
    #1;
    for (int c = 0; c < NCFG; c++) check_cfg(c, "R9");   // power-up value
    @(negedge clk);
    step(1, 0, 0, 5'd3, '0);          // R9: memory starts at INIT_WORD
    step(1, 0, 0, 5'd3, '0);          // R7: registered configs catch up
    step(1, 1, 0, 5'd3, 16'hAAAA);    // R3/R4/R5
    step(1, 1, 0, 5'd3, 16'hBBBB);    // R4: old word AAAA shown
    step(1, 0, 0, 5'd3, '0);          // R2
    step(0, 1, 0, 5'd3, 16'hCCCC);    // R1: disabled write ignored
    step(1, 0, 0, 5'd3, '0);          // R1: still BBBB
    step(1, 1, 1, 5'd9, 16'h1234);    // R6: reset with write in one cycle
    step(1, 0, 0, 5'd9, '0);          // R6: write landed
    step(1, 0, 1, 5'd3, '0);          // R6: reset on read
    step(1, 0, 0, 5'd3, '0);
    step(0, 0, 0, 5'd9, '0);          // R8: register frozen
    step(0, 0, 1, 5'd9, '0);          // R8: reset ignored when disabled
    step(1, 0, 0, 5'd9, '0);
    step(1, 0, 0, 5'd31, '0);         // top address
    step(1, 1, 0, 5'd31, 16'hFFFF);
    step(1, 1, 0, 5'd0, 16'h0001);
    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) == 0), AW'($urandom_range(0, (1 << AW) - 1)),
           DW'($urandom()));
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule